// File: doc/BRIEF.md
# Station Address PROM Access Decoder

This block sits behind a host I/O window of a network controller and decides what each host access means. Offsets below `PROM_BYTES` (16 by default) reach a small station address PROM that is held in the block. Offsets from `PROM_BYTES` upward are passed on to a downstream register port. For the PROM, the block builds multi-byte reads from single bytes and splits multi-byte writes into bytes. Which access sizes it accepts depends on a dword-I/O mode input. Writes to the PROM also need a separate write-enable input.

The host bus is synchronous. The host pulses `host_req` with the address, size, direction and write data, and the block answers with a one-cycle `host_ready` pulse carrying `host_rdata`. PROM accesses and illegal accesses complete one cycle after the block accepts them. A forwarded access completes one cycle after the downstream port signals `rp_ready`. An illegal read returns all ones across the access width, and an illegal write changes nothing. The PROM comes out of reset holding the `PROM_INIT` image, so a station address can be built in.

Top module: `sprom_access_dec`

## Requirements
- R1: After reset, `host_ready` and `rp_req` are 0, and PROM byte i holds `PROM_INIT[8*i+7:8*i]`.
- R2: An offset below `PROM_BYTES` selects the PROM, and the byte index is the low address bits. The size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, and 3 is reserved (always illegal).
- R3: With `dword_mode`=0, 1-byte PROM accesses are legal at any offset and 2-byte accesses are legal only at even offsets. A 4-byte access is illegal.
- R4: With `dword_mode`=1, only 4-byte PROM accesses at offsets with addr[1:0]=0 are legal.
- R5: A multi-byte PROM access is little-endian: the byte at the access offset is bits 7:0, the next byte is bits 15:8, and so on. Read bits above the access width are 0.
- R6: An illegal read returns 0xFF, 0xFFFF or 0xFFFFFFFF for sizes 1, 2 and 4, and 0xFFFFFFFF for the reserved size. An illegal write changes no PROM byte.
- R7: A legal PROM write updates its bytes only when `prom_we` is 1. Otherwise the PROM is left unchanged.
- R8: A PROM or illegal access completes with `host_ready` high for exactly the one cycle after the accepting edge. Every write completes with `host_rdata`=0.
- R9: A 2-byte or 4-byte access at an offset of `PROM_BYTES` or above raises `rp_req` in the next cycle, with address, size, direction and data unchanged. `rp_req` and these fields are held until `rp_ready`. `host_ready` follows in the cycle after that edge, with `rp_rdata` for a read.
- R10: A 1-byte or reserved-size access at an offset of `PROM_BYTES` or above is illegal and is never forwarded.
- R11: `dword_mode` and `prom_we` are sampled only at the accepting edge. Changing them after that edge does not alter the access.
- R12: While a forwarded access is pending, `host_req` is ignored: no PROM byte changes and no extra `host_ready` pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Access request, sampled when idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset in the window |
| host_size | input | 2 | Size code (0:1B, 1:2B, 2:4B, 3:reserved) |
| host_wdata | input | 32 | Write data, little-endian |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_ready | output | 1 | One-cycle completion pulse |
| dword_mode | input | 1 | Selects the dword-only legal set for the PROM |
| prom_we | input | 1 | Allows PROM writes |
| rp_req | output | 1 | Downstream request, held until rp_ready |
| rp_wr | output | 1 | Downstream direction |
| rp_addr | output | ADDR_W | Downstream offset |
| rp_size | output | 2 | Downstream size code |
| rp_wdata | output | 32 | Downstream write data |
| rp_rdata | input | 32 | Downstream read data |
| rp_ready | input | 1 | Downstream completion |

## Verification
The hardest case to reach is a host request that arrives while a forwarded access is still waiting for the downstream port. The bench reaches it by stalling `rp_ready` for several cycles and pulsing a write-enabled PROM write in the middle of the stall. It then reads the PROM back to confirm the write was ignored. Mode sampling is covered in the same way: after every accepting edge the bench inverts `dword_mode` and `prom_we` before the response is checked, so any late sampling of these inputs shows up either in the returned data or in a later read-back.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
   typedef enum logic [1:0] {
      SZ_B1  = 2'd0,
      SZ_B2  = 2'd1,
      SZ_B4  = 2'd2,
      SZ_RSV = 2'd3
   } acc_size_e;

   // all ones across the width of an access
   function automatic logic [31:0] width_ones(input logic [1:0] sz);
      case (acc_size_e'(sz))
         SZ_B1:   width_ones = 32'h0000_00FF;
         SZ_B2:   width_ones = 32'h0000_FFFF;
         default: width_ones = 32'hFFFF_FFFF;
      endcase
   endfunction

   // byte lanes touched by an access
   function automatic logic [3:0] lane_mask(input logic [1:0] sz);
      case (acc_size_e'(sz))
         SZ_B1:   lane_mask = 4'b0001;
         SZ_B2:   lane_mask = 4'b0011;
         SZ_B4:   lane_mask = 4'b1111;
         default: lane_mask = 4'b0000;
      endcase
   endfunction
endpackage

// File: rtl/sprom_legal_dec.sv
module sprom_legal_dec
   import sprom_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              dword_mode,
   output logic              hit_prom,
   output logic              prom_ok,
   output logic              fwd_ok
);
   logic narrow_ok, wide_ok;

   assign hit_prom = (addr[ADDR_W-1:IDX_W] == '0);

   always_comb begin
      narrow_ok = (acc_size_e'(size) == SZ_B1) ||
                  ((acc_size_e'(size) == SZ_B2) && !addr[0]);
      wide_ok   = (acc_size_e'(size) == SZ_B4) && (addr[1:0] == 2'b00);
      prom_ok   = hit_prom && (dword_mode ? wide_ok : narrow_ok);
      fwd_ok    = !hit_prom &&
                  ((acc_size_e'(size) == SZ_B2) || (acc_size_e'(size) == SZ_B4));
   end
endmodule

// File: rtl/sprom_store.sv
module sprom_store #(
   parameter int                      BYTES = 16,
   parameter int                      IDX_W = 4,
   parameter logic [8*BYTES-1:0]      INIT  = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [IDX_W-1:0]     idx,
   input  logic [3:0]           lanes,
   input  logic [31:0]          wdata,
   output logic [8*BYTES-1:0]   image
);
   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      logic       hit;
      logic [7:0] nxt;
      logic [7:0] q;

      always_comb begin
         hit = 1'b0;
         nxt = q;
         for (int l = 0; l < 4; l++) begin
            if (lanes[l] && (IDX_W'(idx + IDX_W'(l)) == IDX_W'(b))) begin
               hit = 1'b1;
               nxt = wdata[8*l +: 8];
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q <= INIT[8*b +: 8];
         else if (we && hit) q <= nxt;
      end

      assign image[8*b +: 8] = q;
   end
endmodule

// File: rtl/sprom_fwd_ctrl.sv
module sprom_fwd_ctrl #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic [31:0]       wdata,
   output logic              busy,
   output logic              done,
   output logic [31:0]       done_rdata,
   output logic              rp_req,
   output logic              rp_wr,
   output logic [ADDR_W-1:0] rp_addr,
   output logic [1:0]        rp_size,
   output logic [31:0]       rp_wdata,
   input  logic [31:0]       rp_rdata,
   input  logic              rp_ready
);
   assign busy = rp_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp_req     <= 1'b0;
         rp_wr      <= 1'b0;
         rp_addr    <= '0;
         rp_size    <= '0;
         rp_wdata   <= '0;
         done       <= 1'b0;
         done_rdata <= '0;
      end else begin
         done <= 1'b0;
         if (!rp_req) begin
            if (start) begin
               rp_req   <= 1'b1;
               rp_wr    <= wr;
               rp_addr  <= addr;
               rp_size  <= size;
               rp_wdata <= wdata;
            end
         end else if (rp_ready) begin
            rp_req     <= 1'b0;
            done       <= 1'b1;
            done_rdata <= rp_wr ? 32'h0 : rp_rdata;
         end
      end
   end
endmodule

// File: rtl/sprom_access_dec.sv
module sprom_access_dec
   import sprom_pkg::*;
#(
   parameter int                        ADDR_W     = 8,
   parameter int                        PROM_BYTES = 16,
   parameter logic [8*PROM_BYTES-1:0]   PROM_INIT  = 128'hFEDC_BA98_7654_3210_EFCD_AB89_6745_2301
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [1:0]        host_size,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              host_ready,
   input  logic              dword_mode,
   input  logic              prom_we,
   output logic              rp_req,
   output logic              rp_wr,
   output logic [ADDR_W-1:0] rp_addr,
   output logic [1:0]        rp_size,
   output logic [31:0]       rp_wdata,
   input  logic [31:0]       rp_rdata,
   input  logic              rp_ready
);
   localparam int IDX_W = $clog2(PROM_BYTES);

   if (PROM_BYTES < 4 || (PROM_BYTES & (PROM_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("PROM_BYTES must be a power of two of at least 4");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the PROM index width");
   end

   logic                    hit_prom, prom_ok, fwd_ok;
   logic                    fwd_busy, fwd_done;
   logic [31:0]             fwd_rdata;
   logic                    accept, local_take, store_we;
   logic [IDX_W-1:0]        idx;
   logic [8*PROM_BYTES-1:0] prom_image;
   logic [31:0]             rd_bytes, local_rdata;
   logic                    loc_rdy_q;
   logic [31:0]             loc_rdata_q;

   assign accept     = host_req && !fwd_busy;
   assign local_take = accept && !fwd_ok;
   assign idx        = host_addr[IDX_W-1:0];
   assign store_we   = local_take && host_wr && prom_ok && prom_we;

   sprom_legal_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
      .addr       (host_addr),
      .size       (host_size),
      .dword_mode (dword_mode),
      .hit_prom   (hit_prom),
      .prom_ok    (prom_ok),
      .fwd_ok     (fwd_ok)
   );

   sprom_store #(.BYTES(PROM_BYTES), .IDX_W(IDX_W), .INIT(PROM_INIT)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (store_we),
      .idx   (idx),
      .lanes (lane_mask(host_size)),
      .wdata (host_wdata),
      .image (prom_image)
   );

   sprom_fwd_ctrl #(.ADDR_W(ADDR_W)) u_fwd (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept && fwd_ok),
      .wr         (host_wr),
      .addr       (host_addr),
      .size       (host_size),
      .wdata      (host_wdata),
      .busy       (fwd_busy),
      .done       (fwd_done),
      .done_rdata (fwd_rdata),
      .rp_req     (rp_req),
      .rp_wr      (rp_wr),
      .rp_addr    (rp_addr),
      .rp_size    (rp_size),
      .rp_wdata   (rp_wdata),
      .rp_rdata   (rp_rdata),
      .rp_ready   (rp_ready)
   );

   // little-endian gather of up to four PROM bytes
   always_comb begin
      for (int l = 0; l < 4; l++) begin
         rd_bytes[8*l +: 8] = prom_image[8*int'(IDX_W'(idx + IDX_W'(l))) +: 8];
      end
      if (host_wr)      local_rdata = 32'h0;
      else if (prom_ok) local_rdata = rd_bytes & width_ones(host_size);
      else              local_rdata = width_ones(host_size);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_rdy_q   <= 1'b0;
         loc_rdata_q <= '0;
      end else begin
         loc_rdy_q <= local_take;
         if (local_take) loc_rdata_q <= local_rdata;
      end
   end

   assign host_ready = loc_rdy_q || fwd_done;
   assign host_rdata = loc_rdy_q ? loc_rdata_q : fwd_rdata;

   logic unused_hit;
   assign unused_hit = hit_prom;
endmodule

// File: rtl/sprom_access_dec_chk.sv
module sprom_access_dec_chk
   import sprom_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int PROM_BYTES = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    host_req,
   input logic                    host_wr,
   input logic [ADDR_W-1:0]       host_addr,
   input logic                    prom_we,
   input logic                    host_ready,
   input logic                    fwd_busy,
   input logic                    fwd_ok,
   input logic                    rp_req,
   input logic                    rp_ready,
   input logic                    rp_wr,
   input logic [ADDR_W-1:0]       rp_addr,
   input logic [1:0]              rp_size,
   input logic [31:0]             rp_wdata,
   input logic [8*PROM_BYTES-1:0] prom_image
);
   localparam int IDX_W = $clog2(PROM_BYTES);

   // R9
   rp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rp_req && !rp_ready |=> rp_req && $stable(rp_addr) && $stable(rp_size) &&
                              $stable(rp_wdata) && $stable(rp_wr));
   // R9
   rp_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rp_req && rp_ready |=> host_ready && !rp_req);
   // R10
   rp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rp_req |-> (rp_addr[ADDR_W-1:IDX_W] != '0) &&
                 (rp_size == SZ_B2 || rp_size == SZ_B4));
   // R7
   we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_req && !fwd_busy && host_wr && !prom_we |=> $stable(prom_image));
   // R8
   local_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_req && !fwd_busy && !fwd_ok |=> host_ready);
   // R12
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_busy && !rp_ready |=> !host_ready && $stable(prom_image));
endmodule

bind sprom_access_dec sprom_access_dec_chk #(.ADDR_W(ADDR_W), .PROM_BYTES(PROM_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_req   (host_req),
   .host_wr    (host_wr),
   .host_addr  (host_addr),
   .prom_we    (prom_we),
   .host_ready (host_ready),
   .fwd_busy   (fwd_busy),
   .fwd_ok     (fwd_ok),
   .rp_req     (rp_req),
   .rp_ready   (rp_ready),
   .rp_wr      (rp_wr),
   .rp_addr    (rp_addr),
   .rp_size    (rp_size),
   .rp_wdata   (rp_wdata),
   .prom_image (prom_image)
);

// File: tb/sprom_access_dec_bench.sv
module sprom_access_dec_bench;
   localparam int                 AW   = 8;
   localparam logic [127:0]       INIT = 128'h5A4B_3C2D_1E0F_F0E1_D2C3_B4A5_9687_7869;

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_req = 0, host_wr = 0, dword_mode = 0, prom_we = 0, rp_ready = 0;
   logic [AW-1:0] host_addr = '0;
   logic [1:0]    host_size = '0;
   logic [31:0]   host_wdata = '0, rp_rdata = '0;
   logic [31:0]   host_rdata, rp_wdata;
   logic          host_ready, rp_req, rp_wr;
   logic [AW-1:0] rp_addr;
   logic [1:0]    rp_size;

   int errors = 0, checks = 0;
   bit finished = 0;
   byte unsigned ref_prom[16];

   always #5 clk = ~clk;

   sprom_access_dec #(.ADDR_W(AW), .PROM_BYTES(16), .PROM_INIT(INIT)) u_sprom_access_dec (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_ready(host_ready), .dword_mode(dword_mode),
      .prom_we(prom_we), .rp_req(rp_req), .rp_wr(rp_wr), .rp_addr(rp_addr),
      .rp_size(rp_size), .rp_wdata(rp_wdata), .rp_rdata(rp_rdata), .rp_ready(rp_ready)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference model: legality, data and PROM update computed behaviourally
   task automatic local_acc(input bit wr, input int addr, input int sz, input logic [31:0] wd,
                            input bit dm, input bit we, input string tag);
      int nb;
      bit legal;
      longint exp;
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
      legal = (addr < 16) && (dm ? (sz == 2 && addr % 4 == 0)
                                 : (sz == 0 || (sz == 1 && addr % 2 == 0)));
      if (wr) exp = 0;
      else if (legal) begin
         exp = 0;
         for (int k = 0; k < nb; k++) exp = exp | (longint'(ref_prom[addr + k]) << (8 * k));
      end else exp = (nb == 0) ? 64'hFFFF_FFFF : ((64'd1 << (8 * nb)) - 1);
      if (wr && legal && we)
         for (int k = 0; k < nb; k++) ref_prom[addr + k] = byte'(wd >> (8 * k));
      host_req = 1; host_wr = wr; host_addr = AW'(addr); host_size = 2'(sz);
      host_wdata = wd; dword_mode = dm; prom_we = we;
      @(negedge clk);
      host_req = 0; dword_mode = !dm; prom_we = !we;   // R11: late changes must not matter
      chk(host_ready === 1'b1, {tag, " ready"}, 32'(host_ready), 1);
      chk(host_rdata === exp[31:0], {tag, " data"}, host_rdata, exp[31:0]);
      chk(rp_req === 1'b0, {tag, " R10 not forwarded"}, 32'(rp_req), 0);
      @(negedge clk);
      chk(host_ready === 1'b0, {tag, " R8 single pulse"}, 32'(host_ready), 0);
   endtask

   task automatic fwd_acc(input bit wr, input int addr, input int sz, input logic [31:0] wd,
                          input int delay, input logic [31:0] resp, input bit intrude);
      host_req = 1; host_wr = wr; host_addr = AW'(addr); host_size = 2'(sz); host_wdata = wd;
      @(negedge clk);
      host_req = 0;
      chk(rp_req === 1'b1, "R9 rp_req raised", 32'(rp_req), 1);
      chk(rp_addr === AW'(addr) && rp_size === 2'(sz) && rp_wr === wr,
          "R9 fields", {rp_addr, 22'(rp_size), 1'(rp_wr), 1'b0}, {AW'(addr), 22'(sz), 1'(wr), 1'b0});
      if (wr) chk(rp_wdata === wd, "R9 wdata", rp_wdata, wd);
      for (int i = 0; i < delay; i++) begin
         if (intrude && i == 0) begin
            host_req = 1; host_wr = 1; host_addr = '0; host_size = 2'd0;
            host_wdata = 32'hAA; dword_mode = 0; prom_we = 1;
         end
         @(negedge clk);
         host_req = 0;
         chk(host_ready === 1'b0, "R12 no ready while pending", 32'(host_ready), 0);
         chk(rp_req === 1'b1, "R9 rp_req held", 32'(rp_req), 1);
      end
      rp_ready = 1; rp_rdata = resp;
      @(negedge clk);
      rp_ready = 0;
      chk(host_ready === 1'b1, "R9 ready after rp_ready", 32'(host_ready), 1);
      chk(host_rdata === (wr ? 32'h0 : resp), "R9 data", host_rdata, wr ? 32'h0 : resp);
      chk(rp_req === 1'b0, "R9 rp_req dropped", 32'(rp_req), 0);
      @(negedge clk);
      chk(host_ready === 1'b0, "R9 single pulse", 32'(host_ready), 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) ref_prom[i] = INIT[8*i +: 8];
      repeat (3) @(negedge clk);
      chk(host_ready === 1'b0, "R1 ready at reset", 32'(host_ready), 0);
      chk(rp_req === 1'b0, "R1 rp_req at reset", 32'(rp_req), 0);
      rst_n = 1;
      @(negedge clk);
      for (int a = 0; a < 16; a++) local_acc(0, a, 0, 0, 0, 0, "R1 R2 reset image byte");
      local_acc(0, 4, 1, 0, 0, 0, "R3 R5 even halfword");
      local_acc(0, 5, 1, 0, 0, 0, "R3 R6 odd halfword");
      local_acc(0, 0, 2, 0, 0, 0, "R3 R6 dword in byte mode");
      local_acc(0, 8, 2, 0, 1, 0, "R4 R5 aligned dword");
      local_acc(0, 6, 2, 0, 1, 0, "R4 R6 misaligned dword");
      local_acc(0, 3, 0, 0, 1, 0, "R4 R6 byte in dword mode");
      local_acc(0, 2, 3, 0, 0, 0, "R6 reserved size");
      local_acc(1, 2, 1, 32'h0000_BEEF, 0, 0, "R7 write disabled");
      local_acc(0, 2, 1, 0, 0, 0, "R7 readback after disabled write");
      local_acc(1, 2, 1, 32'h0000_BEEF, 0, 1, "R7 R11 write enabled");
      local_acc(0, 2, 1, 0, 0, 0, "R7 R11 readback after write");
      local_acc(1, 7, 1, 32'h0000_1234, 0, 1, "R6 illegal odd halfword write");
      local_acc(1, 9, 0, 32'h0000_0055, 1, 1, "R6 illegal byte write in dword mode");
      local_acc(1, 12, 2, 32'hC0DE_F00D, 1, 1, "R4 R5 dword write");
      for (int a = 0; a < 16; a++) local_acc(0, a, 0, 0, 0, 0, "R5 R6 byte readback");
      local_acc(0, 12, 2, 0, 1, 0, "R5 dword readback");
      local_acc(0, 16'h30, 0, 0, 0, 1, "R10 byte above window");
      local_acc(1, 16'h31, 0, 32'h77, 0, 1, "R10 byte write above window");
      local_acc(0, 16'h40, 3, 0, 0, 0, "R10 reserved size above window");
      fwd_acc(0, 16'h20, 1, 0, 0, 32'h0000_5566, 0);
      fwd_acc(0, 16'h24, 2, 0, 3, 32'h89AB_CDEF, 0);
      fwd_acc(1, 16'h44, 2, 32'h1357_9BDF, 2, 32'hDEAD_BEEF, 0);
      fwd_acc(1, 16'h13, 1, 32'h0000_2468, 4, 32'h0, 1);
      local_acc(0, 0, 0, 0, 0, 0, "R12 intruding write ignored");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule